// File: doc/BRIEF.md
# Line and Frame Sync Generator with Odd/Even Field Detection

This block sets the line and frame timing for an image sensor datapath that runs on a pixel clock with 780 clocks per line. It works in one of two modes. With its generate-enable input high it produces active-low horizontal and vertical sync pulses itself. It builds the line from two half-line counts of 390 clocks and counts 525 lines per frame. With generate-enable low its own sync outputs are parked low. The block then follows externally supplied sync inputs, which it registers on the rising clock edge.

In both modes the selected sync pair drives two counters for downstream timing. The pixel counter restarts on each horizontal sync falling edge and the line counter restarts on each vertical sync falling edge. A field detector looks at the horizontal sync level a fixed number of pixel clocks after each vertical falling edge. A low level marks the field odd and a high level marks it even. The fixed delay is 15 clocks by default, roughly 1.2 µs at a 12.27 MHz pixel clock. A clock-enable input qualifies every state change, so the block can run from a faster system clock.

Top module: `sync_field_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous, active low), `hs_n`, `vs_n`, `pix_cnt`, `line_cnt` and `field_odd` all become 0.
- R2: With `gen_en` high and `pix_en` high on every clock, `hs_n` repeats every LINE_CLKS clocks and is low for HS_WIDTH clocks of each period.
- R3: With `gen_en` high, `vs_n` repeats every LINE_CLKS*FRAME_LINES clocks and is low for VS_LINES*LINE_CLKS clocks. Each `vs_n` falling edge falls in the same clock as a `hs_n` falling edge.
- R4: After an enabled clock edge with `gen_en` low, `hs_n` and `vs_n` are both 0.
- R5: `ext_hs_n` and `ext_vs_n` are registered on enabled clock edges. When `gen_en` is low, a falling edge of `ext_hs_n` that is set up before enabled edge A resets `pix_cnt` to 0 at enabled edge A+1.
- R6: `pix_cnt` rises by 1 on each enabled edge that carries no horizontal falling edge, and it saturates at all ones.
- R7: `line_cnt` becomes 0 on a vertical falling edge. Otherwise it rises by 1 on each horizontal falling edge and saturates at all ones. When both edges arrive together, the vertical edge wins.
- R8: FIELD_DLY enabled edges after the edge that detects a vertical falling edge, the registered horizontal sync level is sampled. Low sets `field_odd` to 1 and high sets it to 0. Changes to the horizontal level after that sample leave `field_odd` unchanged.
- R9: While `pix_en` is low, no output or counter changes, and sync input pulses that start and end during that time are ignored.
- R10: With `gen_en` high, `pix_cnt` runs from 0 to LINE_CLKS-1 and `line_cnt` runs from 0 to FRAME_LINES-1, both following the internal sync. `field_odd` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel clock enable |
| gen_en | input | 1 | 1: internal sync generator runs; 0: external sync is followed |
| ext_hs_n | input | 1 | External horizontal sync, active low |
| ext_vs_n | input | 1 | External vertical sync, active low |
| hs_n | output | 1 | Internal horizontal sync, active low, parked low when disabled |
| vs_n | output | 1 | Internal vertical sync, active low, parked low when disabled |
| field_odd | output | 1 | 1 = odd field, 0 = even field |
| pix_cnt | output | $clog2(LINE_CLKS) | Pixels since the last horizontal falling edge |
| line_cnt | output | $clog2(FRAME_LINES) | Lines since the last vertical falling edge |

## Verification
External sync patterns are applied with horizontal and vertical edges placed separately and together. This separates a plain line advance from the case where the vertical edge takes priority. Field detection is tried with the horizontal level held low, held high, switched before the sample point and switched after it. These cases show whether the sample lands on the intended clock and not merely in the right polarity. A long gap with no horizontal edge shows saturation. A stall that carries a short sync pulse shows that the enable gates the input registers. A free-running internal pass over several frames measures the pulse widths, periods, edge alignment and counter ranges directly.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

  typedef struct packed {
    logic hs_n;
    logic vs_n;
  } sync_pair_t;

  localparam sync_pair_t SYNC_IDLE = '{hs_n: 1'b1, vs_n: 1'b1};
  localparam sync_pair_t SYNC_LOW  = '{hs_n: 1'b0, vs_n: 1'b0};

endpackage

// File: rtl/sfg_in_reg.sv
module sfg_in_reg
  import sfg_pkg::*;
#(
  parameter int STAGES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_en,
  input  sync_pair_t d,
  output sync_pair_t q
);

  sync_pair_t stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n)      stg[i] <= SYNC_IDLE;
          else if (pix_en) stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n)      stg[i] <= SYNC_IDLE;
          else if (pix_en) stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sfg_timebase.sv
module sfg_timebase
  import sfg_pkg::*;
#(
  parameter int LINE_CLKS   = 780,
  parameter int FRAME_LINES = 525,
  parameter int HS_WIDTH    = 58,
  parameter int VS_LINES    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_en,
  input  logic       gen_en,
  output sync_pair_t sync_o
);

  localparam int HALF   = LINE_CLKS / 2;
  localparam int HALF_W = $clog2(HALF);
  localparam int LIN_W  = $clog2(FRAME_LINES);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALF - 1);
  localparam logic [LIN_W-1:0]  LINE_LAST = LIN_W'(FRAME_LINES - 1);

  logic [HALF_W-1:0] half_cnt;
  logic              half_sel;
  logic [LIN_W-1:0]  line_q;
  logic              hs_act;
  logic              vs_act;

  assign hs_act = !half_sel && (32'(half_cnt) < HS_WIDTH);
  assign vs_act = 32'(line_q) < VS_LINES;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_cnt <= '0;
      half_sel <= 1'b0;
      line_q   <= '0;
      sync_o   <= SYNC_LOW;
    end else if (pix_en) begin
      if (!gen_en) begin
        half_cnt <= '0;
        half_sel <= 1'b0;
        line_q   <= '0;
        sync_o   <= SYNC_LOW;
      end else begin
        sync_o.hs_n <= !hs_act;
        sync_o.vs_n <= !vs_act;
        if (half_cnt == HALF_LAST) begin
          half_cnt <= '0;
          half_sel <= !half_sel;
          if (half_sel) line_q <= (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
        end else begin
          half_cnt <= half_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sfg_counters.sv
module sfg_counters
  import sfg_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int LIN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  sync_pair_t       sync_i,
  output logic             hs_fall,
  output logic             vs_fall,
  output logic [PIX_W-1:0] pix_cnt,
  output logic [LIN_W-1:0] line_cnt
);

  sync_pair_t prev;

  assign hs_fall = prev.hs_n && !sync_i.hs_n;
  assign vs_fall = prev.vs_n && !sync_i.vs_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev     <= SYNC_LOW;
      pix_cnt  <= '0;
      line_cnt <= '0;
    end else if (pix_en) begin
      prev <= sync_i;
      if (hs_fall)        pix_cnt <= '0;
      else if (~&pix_cnt) pix_cnt <= pix_cnt + 1'b1;
      if (vs_fall)                  line_cnt <= '0;
      else if (hs_fall && ~&line_cnt) line_cnt <= line_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sfg_field_detect.sv
module sfg_field_detect #(
  parameter int FIELD_DLY = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_en,
  input  logic vs_fall,
  input  logic hs_level,
  output logic field_odd
);

  localparam int DLY_W = $clog2(FIELD_DLY + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(FIELD_DLY);

  logic [DLY_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt  <= '0;
      field_odd <= 1'b0;
    end else if (pix_en) begin
      if (vs_fall)             wait_cnt <= DLY_LOAD;
      else if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
      if (!vs_fall && wait_cnt == DLY_W'(1)) field_odd <= !hs_level;
    end
  end

endmodule

// File: rtl/sync_field_gen.sv
module sync_field_gen
  import sfg_pkg::*;
#(
  parameter int LINE_CLKS   = 780,
  parameter int FRAME_LINES = 525,
  parameter int HS_WIDTH    = 58,
  parameter int VS_LINES    = 3,
  parameter int FIELD_DLY   = 15,
  parameter int IN_STAGES   = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           pix_en,
  input  logic                           gen_en,
  input  logic                           ext_hs_n,
  input  logic                           ext_vs_n,
  output logic                           hs_n,
  output logic                           vs_n,
  output logic                           field_odd,
  output logic [$clog2(LINE_CLKS)-1:0]   pix_cnt,
  output logic [$clog2(FRAME_LINES)-1:0] line_cnt
);

  localparam int PIX_W = $clog2(LINE_CLKS);
  localparam int LIN_W = $clog2(FRAME_LINES);

  sync_pair_t ext_in, ext_q, gen_q, sel;
  logic       hs_fall, vs_fall;

  assign ext_in = '{hs_n: ext_hs_n, vs_n: ext_vs_n};

  sfg_in_reg #(.STAGES(IN_STAGES)) u_in (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .d(ext_in), .q(ext_q)
  );

  sfg_timebase #(
    .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES),
    .HS_WIDTH(HS_WIDTH), .VS_LINES(VS_LINES)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .gen_en(gen_en), .sync_o(gen_q)
  );

  assign sel = gen_en ? gen_q : ext_q;

  sfg_counters #(.PIX_W(PIX_W), .LIN_W(LIN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .sync_i(sel),
    .hs_fall(hs_fall), .vs_fall(vs_fall), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
  );

  sfg_field_detect #(.FIELD_DLY(FIELD_DLY)) u_fld (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .vs_fall(vs_fall),
    .hs_level(sel.hs_n), .field_odd(field_odd)
  );

  assign hs_n = gen_q.hs_n;
  assign vs_n = gen_q.vs_n;

endmodule

// File: rtl/sfg_checker.sv
module sfg_checker #(
  parameter int PIX_W = 10,
  parameter int LIN_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             gen_en,
  input logic             hs_n,
  input logic             vs_n,
  input logic             field_odd,
  input logic [PIX_W-1:0] pix_cnt,
  input logic [LIN_W-1:0] line_cnt
);

  AST_GEN_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !gen_en) |=> (!hs_n && !vs_n)); // R4

  AST_VS_WITH_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && $fell(vs_n)) |-> $fell(hs_n)); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !pix_en) |=> ($stable(pix_cnt) && $stable(line_cnt) &&
                            $stable(field_odd) && $stable(hs_n) && $stable(vs_n))); // R9

  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && pix_en) |=> (pix_cnt == '0 || pix_cnt == $past(pix_cnt) + 1'b1 ||
                           (&$past(pix_cnt) && &pix_cnt))); // R6

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && pix_en) |=> (line_cnt == '0 || line_cnt == $past(line_cnt) ||
                           line_cnt == $past(line_cnt) + 1'b1)); // R7

endmodule

bind sync_field_gen sfg_checker #(
  .PIX_W($clog2(LINE_CLKS)), .LIN_W($clog2(FRAME_LINES))
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .gen_en(gen_en), .hs_n(hs_n),
  .vs_n(vs_n), .field_odd(field_odd), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
);

// File: tb/sim_sync_field_gen.sv
`timescale 1ns/1ps
module sim_sync_field_gen;

  localparam int LC  = 100;
  localparam int FL  = 12;
  localparam int HW  = 20;
  localparam int VL  = 3;
  localparam int FD  = 15;
  localparam int PW  = $clog2(LC);
  localparam int LW  = $clog2(FL);
  localparam int PIX_MAX = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pix_en = 1'b1, gen_en = 1'b0;
  logic ext_hs_n = 1'b1, ext_vs_n = 1'b1;
  logic hs_n, vs_n, field_odd;
  logic [PW-1:0] pix_cnt;
  logic [LW-1:0] line_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_field_gen #(
    .LINE_CLKS(LC), .FRAME_LINES(FL), .HS_WIDTH(HW), .VS_LINES(VL),
    .FIELD_DLY(FD), .IN_STAGES(1)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .gen_en(gen_en),
    .ext_hs_n(ext_hs_n), .ext_vs_n(ext_vs_n), .hs_n(hs_n), .vs_n(vs_n),
    .field_odd(field_odd), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1
  task automatic t_reset();
    rst_n = 1'b0;
    tick(3);
    check({hs_n, vs_n, field_odd} == 3'b000, "R1 sync/field", {hs_n, vs_n, field_odd}, 0);
    check(pix_cnt == 0 && line_cnt == 0, "R1 counters", pix_cnt + line_cnt, 0);
    rst_n = 1'b1;
  endtask

  // R4 with the generator off while external sync runs
  task automatic t_gen_off();
    int bad = 0;
    for (int i = 0; i < 50; i++) begin
      tick(1);
      if (hs_n || vs_n) bad++;
    end
    check(bad == 0, "R4 parked low", bad, 0);
  endtask

  // R5, R6
  task automatic t_ext_pix();
    ext_hs_n = 1'b0;
    tick(2);
    check(pix_cnt == 0, "R5 pix reset on ext fall", pix_cnt, 0);
    tick(7);
    check(pix_cnt == 7, "R6 pix step", pix_cnt, 7);
    ext_hs_n = 1'b1;
    tick(PIX_MAX + 20);
    check(pix_cnt == PIX_MAX, "R6 saturate", pix_cnt, PIX_MAX);
  endtask

  // R7, R8 odd
  task automatic t_line_odd();
    ext_vs_n = 1'b0; ext_hs_n = 1'b0;
    tick(2);
    check(line_cnt == 0, "R7 vertical priority", line_cnt, 0);
    for (int i = 0; i < 3; i++) begin
      tick(5); ext_hs_n = 1'b1;
      tick(5); ext_hs_n = 1'b0;
    end
    tick(2);
    check(line_cnt == 3, "R7 line step", line_cnt, 3);
    check(field_odd == 1'b1, "R8 odd field", field_odd, 1);
    ext_vs_n = 1'b1; ext_hs_n = 1'b1;
    tick(5);
  endtask

  // R8: vertical fall, horizontal level switched at hs_at (negedges after)
  task automatic t_field(input bit hs0, input int hs_at, input bit exp_odd, input string tag);
    ext_hs_n = hs0;
    tick(3);
    ext_vs_n = 1'b0;
    tick(hs_at);
    ext_hs_n = !hs0;
    tick(40 - hs_at);
    check(field_odd == exp_odd, tag, field_odd, exp_odd);
    ext_vs_n = 1'b1;
    tick(3);
  endtask

  // R9
  task automatic t_stall();
    int p0, l0;
    ext_hs_n = 1'b1; ext_vs_n = 1'b1;
    tick(3);
    p0 = pix_cnt; l0 = line_cnt;
    pix_en = 1'b0;
    tick(3); ext_hs_n = 1'b0; ext_vs_n = 1'b0;
    tick(4); ext_hs_n = 1'b1; ext_vs_n = 1'b1;
    tick(3);
    check(pix_cnt == p0 && line_cnt == l0, "R9 frozen", pix_cnt, p0);
    pix_en = 1'b1;
    tick(5);
    check(pix_cnt == ((p0 + 5 > PIX_MAX) ? PIX_MAX : p0 + 5), "R9 pulse ignored",
          pix_cnt, p0 + 5);
  endtask

  // R2, R3, R10
  task automatic t_internal();
    int t = 0, hf = -1, vf = -1, vfirst = -1;
    int bad_hp = 0, bad_hw = 0, bad_vp = 0, bad_vw = 0, bad_al = 0;
    int n_hp = 0, n_vp = 0, pmax = 0, lmax = 0;
    logic ph, pv;
    gen_en = 1'b1;
    tick(1);
    ph = hs_n; pv = vs_n;
    for (int i = 0; i < 3 * LC * FL + 50; i++) begin
      tick(1); t++;
      if (ph && !hs_n) begin
        if (hf >= 0) begin n_hp++; if (t - hf != LC) bad_hp++; end
        hf = t;
      end
      if (!ph && hs_n && hf >= 0 && t - hf != HW) bad_hw++;
      if (pv && !vs_n) begin
        if (!(ph && !hs_n)) bad_al++;
        if (vf >= 0) begin n_vp++; if (t - vf != LC * FL) bad_vp++; end
        vf = t;
        if (vfirst < 0) vfirst = t;
      end
      if (!pv && vs_n && vf >= 0 && t - vf != VL * LC) bad_vw++;
      if (vfirst >= 0 && t > vfirst + 2) begin
        if (pix_cnt > pmax) pmax = pix_cnt;
        if (line_cnt > lmax) lmax = line_cnt;
      end
      ph = hs_n; pv = vs_n;
    end
    check(bad_hp == 0 && n_hp > 20, "R2 hs period", bad_hp, 0);
    check(bad_hw == 0, "R2 hs width", bad_hw, 0);
    check(bad_vp == 0 && n_vp >= 2, "R3 vs period", bad_vp, 0);
    check(bad_vw == 0, "R3 vs width", bad_vw, 0);
    check(bad_al == 0, "R3 vs/hs aligned", bad_al, 0);
    check(pmax == LC - 1, "R10 pix range", pmax, LC - 1);
    check(lmax == FL - 1, "R10 line range", lmax, FL - 1);
    check(field_odd == 1'b1, "R10 field odd", field_odd, 1);
    gen_en = 1'b0;
    tick(1);
    check(!hs_n && !vs_n, "R4 disable next edge", {hs_n, vs_n}, 0);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_gen_off();
    t_ext_pix();
    t_line_odd();
    t_field(1'b1, 30, 1'b0, "R8 even field");
    t_field(1'b1, 5, 1'b1, "R8 change before sample");
    t_field(1'b1, 25, 1'b0, "R8 change after sample");
    t_field(1'b0, 25, 1'b1, "R8 low then high late");
    t_stall();
    t_internal();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule